// File: doc/BRIEF.md
# Multi-Domain Clock Divider and Gating Unit

This block turns one fast root clock and one slow reference clock into single-cycle enable strobes for six subsystem domains: the processor core, its memory-management unit, the GPIO block, the public peripherals, the internal timers and the watchdog. Every strobe lives in the root-clock domain. A downstream register bank in a domain advances only on cycles where that domain's strobe is high. The effect is the same as running that bank on a slower or gated clock, but without a second clock tree.

Each domain has its own way of deriving its rate:
- The core, MMU and GPIO domains have their own power-of-two divider fields.
- The timers take either a fixed half-rate root tick or the reference.
- The peripherals always take the reference.
- The watchdog counts reference edges and strobes once every fourteen.

Software enable and idle bits arrive as plain input levels. An idle bit only matters while the global idle request is high. While watchdog mode is active, the watchdog strobe cannot be stopped.

There is no data stream in or out, so the block has no valid/ready handshake. Every pin is a plain control level or strobe.

Top module: `domain_clk_strober`

## Requirements
- R1: The core divider field selects the strobe period in root cycles: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4, and 2'b11 gives 8.
- R2: The MMU strobe follows its own 2-bit field, using the R1 encoding. Its rate does not depend on the core field.
- R3: A new divider value is adopted only at the end of the current count. The interval that is running when the field changes keeps its old length, and the intervals after it use the new length.
- R4: While `core_in_reset` is high, the core strobe is silent unless `core_run_in_reset` is high. While `core_in_reset` is low, the core strobe runs.
- R5: A gated domain (GPIO, peripheral, timer, watchdog) produces strobes exactly when its enable bit is high and not (its idle bit AND `idle_req`). An idle bit with `idle_req` low has no effect.
- R6: Each rising edge of `ref_clk` yields exactly one single-cycle reference strobe. The reference strobe appears two to three root cycles after the edge, and it drives the peripheral domain.
- R7: With `gpio_use_ref` high, the GPIO domain runs at the reference rate. With it low, the GPIO domain runs at the rate of its own divider field, using the R1 encoding.
- R8: With `tmr_use_ref` low, the timer domain strobes every 2 root cycles. With it high, the timer domain strobes once per reference edge.
- R9: The watchdog domain strobes once for every 14 reference rising edges.
- R10: While `wdt_mode` is high, the watchdog strobes continue even when `wdt_en` is low or the watchdog is idled.
- R11: `rst_n` is a synchronous, active-low reset. It clears all counters. While it is low, all six strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast root clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock, sampled as data |
| idle_req | input | 1 | Global idle request; arms the idle bits |
| core_div | input | 2 | Core divider field |
| core_in_reset | input | 1 | Core is held in reset |
| core_run_in_reset | input | 1 | Keep core strobe running during core reset |
| mmu_div | input | 2 | MMU divider field |
| gpio_div | input | 2 | GPIO divider field |
| gpio_use_ref | input | 1 | GPIO source: 1 reference, 0 divided root |
| gpio_en | input | 1 | GPIO domain enable |
| gpio_idle | input | 1 | GPIO idle bit |
| periph_en | input | 1 | Peripheral domain enable |
| periph_idle | input | 1 | Peripheral idle bit |
| tmr_use_ref | input | 1 | Timer source: 1 reference, 0 root/2 |
| tmr_en | input | 1 | Timer domain enable |
| tmr_idle | input | 1 | Timer idle bit |
| wdt_en | input | 1 | Watchdog domain enable |
| wdt_idle | input | 1 | Watchdog idle bit |
| wdt_mode | input | 1 | Watchdog mode; forbids gating the watchdog |
| core_stb | output | 1 | Core domain enable strobe |
| mmu_stb | output | 1 | MMU domain enable strobe |
| gpio_stb | output | 1 | GPIO domain enable strobe |
| periph_stb | output | 1 | Peripheral domain enable strobe |
| tmr_stb | output | 1 | Timer domain enable strobe |
| wdt_stb | output | 1 | Watchdog domain enable strobe |

## Verification
A power-of-two counter or latched limit that has gone wrong shows up as a strobe spacing that is not the selected period. It is visible within one period, at most eight root cycles. A fault in the reference synchronizer shows up as a missing, doubled or stretched strobe within three root cycles of a reference edge. A wrong watchdog edge count shows up only as a wrong strobe count over fourteen reference periods. For that reason the bench compares strobe totals over windows that are whole multiples of every period, rather than the phase of individual strobes.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;

  localparam int DIV_CNT_W = 3;
  localparam int WDT_DIVIDE = 14;
  localparam int REF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    DIV_BY_1 = 2'b00,
    DIV_BY_2 = 2'b01,
    DIV_BY_4 = 2'b10,
    DIV_BY_8 = 2'b11
  } div_sel_e;

  // Terminal count for a divider field (period minus one).
  function automatic logic [DIV_CNT_W-1:0] div_last(input logic [1:0] sel);
    case (sel)
      DIV_BY_1: div_last = DIV_CNT_W'(0);
      DIV_BY_2: div_last = DIV_CNT_W'(1);
      DIV_BY_4: div_last = DIV_CNT_W'(3);
      default:  div_last = DIV_CNT_W'(7);
    endcase
  endfunction

endpackage

// File: rtl/pow2_divider.sv
module pow2_divider
  import clkdom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  output logic       tick_o
);

  logic [DIV_CNT_W-1:0] cnt_q;
  logic [DIV_CNT_W-1:0] last_q;
  logic                 at_end;

  assign at_end = (cnt_q == last_q);
  assign tick_o = rst_n & at_end;

  // The limit is reloaded only when the count wraps, so a field change
  // never shortens or stretches the interval in progress.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= div_last(sel_i);
    end else if (at_end) begin
      cnt_q  <= '0;
      last_q <= div_last(sel_i);
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_cnt_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_q);

  p_limit_at_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (last_q != $past(last_q))) |-> $past(cnt_q == last_q));

endmodule

// File: rtl/ref_edge_detect.sv
module ref_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ref_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = rst_n & sync_q[STAGES-1] & ~prev_q;

  p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ref_count_divider.sv
module ref_count_divider #(
  parameter int DIVIDE = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic tick_o
);

  localparam int W = $clog2(DIVIDE);
  localparam logic [W-1:0] LAST = W'(DIVIDE - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = step_i & (cnt_q == LAST);

  p_cnt_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  p_hold_between_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(step_i)) |-> $stable(cnt_q));

endmodule

// File: rtl/domain_gate.sv
module domain_gate (
  input  logic rst_n,
  input  logic src_i,
  input  logic en_i,
  input  logic idle_i,
  input  logic idle_req_i,
  input  logic hold_i,
  output logic stb_o
);

  logic run;

  assign run   = hold_i | (en_i & ~(idle_i & idle_req_i));
  assign stb_o = rst_n & src_i & run;

endmodule

// File: rtl/domain_clk_strober.sv
module domain_clk_strober
  import clkdom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk,
  input  logic       idle_req,
  input  logic [1:0] core_div,
  input  logic       core_in_reset,
  input  logic       core_run_in_reset,
  input  logic [1:0] mmu_div,
  input  logic [1:0] gpio_div,
  input  logic       gpio_use_ref,
  input  logic       gpio_en,
  input  logic       gpio_idle,
  input  logic       periph_en,
  input  logic       periph_idle,
  input  logic       tmr_use_ref,
  input  logic       tmr_en,
  input  logic       tmr_idle,
  input  logic       wdt_en,
  input  logic       wdt_idle,
  input  logic       wdt_mode,
  output logic       core_stb,
  output logic       mmu_stb,
  output logic       gpio_stb,
  output logic       periph_stb,
  output logic       tmr_stb,
  output logic       wdt_stb
);

  localparam int N_GATED = 4;
  localparam int G_GPIO  = 0;
  localparam int G_PER   = 1;
  localparam int G_TMR   = 2;
  localparam int G_WDT   = 3;

  logic core_tick, mmu_tick, gpio_tick, tmr_tick, wdt_tick, ref_rise;
  logic [N_GATED-1:0] src_v, en_v, idle_v, hold_v, stb_v;

  pow2_divider u_core_div (.clk(clk), .rst_n(rst_n), .sel_i(core_div), .tick_o(core_tick));
  pow2_divider u_mmu_div  (.clk(clk), .rst_n(rst_n), .sel_i(mmu_div),  .tick_o(mmu_tick));
  pow2_divider u_gpio_div (.clk(clk), .rst_n(rst_n), .sel_i(gpio_div), .tick_o(gpio_tick));
  pow2_divider u_tmr_div  (.clk(clk), .rst_n(rst_n), .sel_i(DIV_BY_2), .tick_o(tmr_tick));

  ref_edge_detect #(.STAGES(REF_SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_clk), .rise_o(ref_rise)
  );

  ref_count_divider #(.DIVIDE(WDT_DIVIDE)) u_wdt_div (
    .clk(clk), .rst_n(rst_n), .step_i(ref_rise), .tick_o(wdt_tick)
  );

  // Ungated domains
  assign core_stb = core_tick & (~core_in_reset | core_run_in_reset);
  assign mmu_stb  = mmu_tick;

  // Source selection per gated domain
  assign src_v[G_GPIO] = gpio_use_ref ? ref_rise : gpio_tick;
  assign src_v[G_PER]  = ref_rise;
  assign src_v[G_TMR]  = tmr_use_ref ? ref_rise : tmr_tick;
  assign src_v[G_WDT]  = wdt_tick;

  assign en_v   = {wdt_en,   tmr_en,   periph_en,   gpio_en};
  assign idle_v = {wdt_idle, tmr_idle, periph_idle, gpio_idle};
  assign hold_v = {wdt_mode, 1'b0,     1'b0,        1'b0};

  for (genvar g = 0; g < N_GATED; g++) begin : g_gate
    domain_gate u_gate (
      .rst_n      (rst_n),
      .src_i      (src_v[g]),
      .en_i       (en_v[g]),
      .idle_i     (idle_v[g]),
      .idle_req_i (idle_req),
      .hold_i     (hold_v[g]),
      .stb_o      (stb_v[g])
    );
  end

  assign gpio_stb   = stb_v[G_GPIO];
  assign periph_stb = stb_v[G_PER];
  assign tmr_stb    = stb_v[G_TMR];
  assign wdt_stb    = stb_v[G_WDT];

  p_core_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_in_reset && !core_run_in_reset) |-> !core_stb);

  p_periph_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_stb |-> (periph_en && !(periph_idle && idle_req)));

  p_wdt_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_mode && wdt_tick) |-> wdt_stb);

  p_wdt_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_stb |-> ref_rise);

endmodule

// File: tb/domain_clk_strober_tb.sv
module domain_clk_strober_tb;

  localparam int CLK_PERIOD = 10;
  localparam int REF_HALF   = 4;
  localparam int WIN        = 224;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic idle_req = 1'b0;
  logic [1:0] core_div = 2'b00, mmu_div = 2'b00, gpio_div = 2'b00;
  logic core_in_reset = 1'b0, core_run_in_reset = 1'b0;
  logic gpio_use_ref = 1'b0, gpio_en = 1'b0, gpio_idle = 1'b0;
  logic periph_en = 1'b0, periph_idle = 1'b0;
  logic tmr_use_ref = 1'b0, tmr_en = 1'b0, tmr_idle = 1'b0;
  logic wdt_en = 1'b0, wdt_idle = 1'b0, wdt_mode = 1'b0;
  logic core_stb, mmu_stb, gpio_stb, periph_stb, tmr_stb, wdt_stb;

  int n_tests = 0;
  int n_fail = 0;
  int c_core, c_mmu, c_gpio, c_per, c_tmr, c_wdt;
  int per_double;
  bit done = 1'b0;

  domain_clk_strober u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .idle_req(idle_req),
    .core_div(core_div), .core_in_reset(core_in_reset),
    .core_run_in_reset(core_run_in_reset), .mmu_div(mmu_div),
    .gpio_div(gpio_div), .gpio_use_ref(gpio_use_ref), .gpio_en(gpio_en),
    .gpio_idle(gpio_idle), .periph_en(periph_en), .periph_idle(periph_idle),
    .tmr_use_ref(tmr_use_ref), .tmr_en(tmr_en), .tmr_idle(tmr_idle),
    .wdt_en(wdt_en), .wdt_idle(wdt_idle), .wdt_mode(wdt_mode),
    .core_stb(core_stb), .mmu_stb(mmu_stb), .gpio_stb(gpio_stb),
    .periph_stb(periph_stb), .tmr_stb(tmr_stb), .wdt_stb(wdt_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (REF_HALF) @(negedge clk);
      ref_clk = ~ref_clk;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_window(input int n);
    bit prev_per = 1'b0;
    c_core = 0; c_mmu = 0; c_gpio = 0; c_per = 0; c_tmr = 0; c_wdt = 0;
    per_double = 0;
    for (int i = 0; i < n; i++) begin
      step();
      c_core += int'(core_stb);
      c_mmu  += int'(mmu_stb);
      c_gpio += int'(gpio_stb);
      c_per  += int'(periph_stb);
      c_tmr  += int'(tmr_stb);
      c_wdt  += int'(wdt_stb);
      if (prev_per && periph_stb) per_double++;
      prev_per = periph_stb;
    end
  endtask

  task automatic settle();
    repeat (16) step();
  endtask

  // R11: quiet while in reset, even with everything enabled
  task automatic t_reset_quiet();
    core_run_in_reset = 1'b1; gpio_en = 1'b1; periph_en = 1'b1;
    tmr_en = 1'b1; wdt_en = 1'b1; wdt_mode = 1'b1;
    rst_n = 1'b0;
    run_window(WIN);
    check("R11 strobes in reset", c_core + c_mmu + c_gpio + c_per + c_tmr + c_wdt, 0);
    rst_n = 1'b1;
    core_run_in_reset = 1'b0; gpio_en = 1'b0; periph_en = 1'b0;
    tmr_en = 1'b0; wdt_en = 1'b0; wdt_mode = 1'b0;
    settle();
    run_window(WIN);
    check("R11 gated domains off after reset", c_gpio + c_per + c_tmr + c_wdt, 0);
  endtask

  // R1: each core divider code
  task automatic t_core_divs();
    for (int s = 0; s < 4; s++) begin
      core_div = 2'(s);
      settle();
      run_window(WIN);
      check($sformatf("R1 core div code %0d", s), c_core, WIN >> s);
    end
  endtask

  // R2: MMU independent of core field
  task automatic t_mmu_indep();
    core_div = 2'b11; mmu_div = 2'b00;
    settle(); run_window(WIN);
    check("R2 mmu div1 with core div8", c_mmu, WIN);
    check("R2 core div8 with mmu div1", c_core, WIN / 8);
    core_div = 2'b00; mmu_div = 2'b10;
    settle(); run_window(WIN);
    check("R2 mmu div4 with core div1", c_mmu, WIN / 4);
  endtask

  // R3: change takes effect only at the wrap
  task automatic t_div_change();
    int gap;
    core_div = 2'b11;
    settle();
    do step(); while (!core_stb);
    repeat (3) step();
    core_div = 2'b01;
    gap = 3;
    do begin step(); gap++; end while (!core_stb);
    check("R3 interval in progress keeps old length", gap, 8);
    gap = 0;
    do begin step(); gap++; end while (!core_stb);
    check("R3 next interval uses new length", gap, 2);
    core_div = 2'b00;
  endtask

  // R4: core gating while core held in reset
  task automatic t_core_reset_gate();
    core_div = 2'b00; core_in_reset = 1'b1; core_run_in_reset = 1'b0;
    settle(); run_window(WIN);
    check("R4 core silent in core reset", c_core, 0);
    core_run_in_reset = 1'b1;
    run_window(WIN);
    check("R4 core runs with run-in-reset", c_core, WIN);
    core_in_reset = 1'b0; core_run_in_reset = 1'b0;
    run_window(WIN);
    check("R4 core runs out of reset", c_core, WIN);
  endtask

  // R5: enable and idle gating
  task automatic t_enable_idle();
    gpio_use_ref = 1'b0; gpio_div = 2'b10;
    periph_en = 1'b0; gpio_en = 1'b0;
    settle(); run_window(WIN);
    check("R5 gpio disabled", c_gpio, 0);
    check("R5 periph disabled", c_per, 0);
    gpio_en = 1'b1; gpio_idle = 1'b1; periph_en = 1'b1; periph_idle = 1'b1;
    tmr_en = 1'b1; tmr_idle = 1'b1; idle_req = 1'b0;
    run_window(WIN);
    check("R5 gpio idle bit without request", c_gpio, WIN / 4);
    check("R5 periph idle bit without request", c_per, WIN / 8);
    idle_req = 1'b1;
    run_window(WIN);
    check("R5 gpio idled", c_gpio, 0);
    check("R5 periph idled", c_per, 0);
    check("R5 timer idled", c_tmr, 0);
    gpio_idle = 1'b0; periph_idle = 1'b0; tmr_idle = 1'b0;
    run_window(WIN);
    check("R5 gpio runs with request but no idle bit", c_gpio, WIN / 4);
    idle_req = 1'b0;
  endtask

  // R6: one clean strobe per reference edge
  task automatic t_ref_edges();
    periph_en = 1'b1;
    run_window(WIN);
    check("R6 periph strobes per ref edge", c_per, WIN / (2 * REF_HALF));
    check("R6 periph strobe wider than one cycle", per_double, 0);
  endtask

  // R7: GPIO source select
  task automatic t_gpio_src();
    gpio_en = 1'b1; gpio_div = 2'b01; gpio_use_ref = 1'b1;
    settle(); run_window(WIN);
    check("R7 gpio from reference", c_gpio, WIN / (2 * REF_HALF));
    gpio_use_ref = 1'b0;
    settle(); run_window(WIN);
    check("R7 gpio from root div2", c_gpio, WIN / 2);
  endtask

  // R8: timer source select
  task automatic t_timer_src();
    tmr_en = 1'b1; tmr_use_ref = 1'b0;
    settle(); run_window(WIN);
    check("R8 timer root/2", c_tmr, WIN / 2);
    tmr_use_ref = 1'b1;
    settle(); run_window(WIN);
    check("R8 timer from reference", c_tmr, WIN / (2 * REF_HALF));
  endtask

  // R9 and R10: watchdog rate and mode hold
  task automatic t_watchdog();
    wdt_mode = 1'b0; wdt_en = 1'b1; wdt_idle = 1'b0; idle_req = 1'b0;
    run_window(WIN);
    check("R9 watchdog one per 14 ref edges", c_wdt, WIN / (2 * REF_HALF * 14));
    wdt_en = 1'b0;
    run_window(WIN);
    check("R9 watchdog disabled", c_wdt, 0);
    wdt_mode = 1'b1;
    run_window(WIN);
    check("R10 watchdog mode overrides disable", c_wdt, 2);
    wdt_en = 1'b1; wdt_idle = 1'b1; idle_req = 1'b1;
    run_window(WIN);
    check("R10 watchdog mode overrides idle", c_wdt, 2);
    wdt_mode = 1'b0;
    run_window(WIN);
    check("R10 watchdog idled outside mode", c_wdt, 0);
    idle_req = 1'b0; wdt_idle = 1'b0;
  endtask

  initial begin
    repeat (4) step();
    t_reset_quiet();
    t_core_divs();
    t_mmu_indep();
    t_div_change();
    t_core_reset_gate();
    t_enable_idle();
    t_ref_edges();
    t_gpio_src();
    t_timer_src();
    t_watchdog();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule